// File: doc/BRIEF.md
# Two-Channel Bus Activity Monitor

This block watches bus activity on two independent channels. Every activity pulse adds a programmable weight to that channel's running count. A global millisecond tick drives a shared sampling period. When a period ends, each running channel closes its count into a sample and updates an exponential moving average of recent samples. It then compares the sample with a raw watermark pair and the fresh average with an average watermark pair, and restarts counting from zero.

A raw watermark breach must repeat over a programmable number of back-to-back periods before it is reported. An average breach is reported at once. Reports latch in sticky status bits. The single interrupt line is the OR of the status bits whose enables are set in a running channel. Software reads the average and the status through a plain register port, then retunes the watermarks and clears the status. Events and ticks are single-cycle pulses with no handshake: the monitor never pushes back, and nothing on its inputs can be stalled.

Top module: `actmon_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While a channel's control word has bit 31 (enable) and bit 18 (periodic) set, each cycle with its `act_evt` bit high adds the weight register (channel offset 0x18) to the period count. The count saturates at all ones.
- R3: The global register at 0x004 holds P in bits 7:0. A period ends on every (P+1)-th `ms_tick` pulse counted from the last write to that register.
- R4: At a period end the average (read at offset 0x20, loaded by a write to offset 0x0C) becomes avg + ((sample - avg) >>> (K+1)). The arithmetic is signed with a floor shift, and K is control bits 12:10.
- R5: If the sample exceeds the upper watermark (offset 0x04) in Nu consecutive periods, status bit 31 is set, provided control bit 30 is set. Nu-1 sits in control bits 28:26. The run restarts after it fires and after any non-breaching period.
- R6: If the sample is below the lower watermark (offset 0x08) in Nd consecutive periods, status bit 30 is set, provided control bit 29 is set. Nd-1 sits in control bits 25:23, and the same restart rules as R5 apply.
- R7: If the updated average exceeds offset 0x10, status bit 29 is set when control bit 21 is set. If it is below offset 0x14, status bit 28 is set when control bit 20 is set.
- R8: Status bits (offset 0x24) are sticky. Writing a one to a bit clears it. A bit that is set in the same cycle as its clear stays set.
- R9: `irq` is high when a channel has bit 31 set and a status bit whose enable is set (31↔30, 30↔29, 29↔21, 28↔20). The global register 0x000 shows channel 0's interrupt on bit 26 and channel 1's on bit 25.
- R10: A channel without both bit 31 and bit 18 set ignores events and period ends: its average and status do not change. Writing zero to the control word also masks its interrupt.
- R11: Channel register blocks sit at 0x1C0 and 0x200. Unmapped addresses and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| act_evt | input | 2 | Activity pulse per channel |
| ms_tick | input | 1 | One-cycle millisecond tick |
| irq | output | 1 | Combined interrupt |

## Verification
Two things can fall in the same cycle: a software write that clears status, and a period end that sets a status bit. The bench provokes this by raising `ms_tick` in the very cycle that a write of all ones reaches channel 0's status register. The closing sample is chosen so that the average watermark breaches at that period end. The bench then reads the status and expects the newly raised bit to have survived the clear. An activity pulse that coincides with a period end is another collision. R2 and R4 give it a defined outcome: the pulse counts toward the period that is closing.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 10;
  localparam int OFF_W    = 6;
  localparam int PERIOD_W = 8;

  localparam logic [OFF_W-1:0] OFF_CTRL   = 6'h00;
  localparam logic [OFF_W-1:0] OFF_UPPER  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_LOWER  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_SEED   = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_AVG_HI = 6'h10;
  localparam logic [OFF_W-1:0] OFF_AVG_LO = 6'h14;
  localparam logic [OFF_W-1:0] OFF_WEIGHT = 6'h18;
  localparam logic [OFF_W-1:0] OFF_AVG    = 6'h20;
  localparam logic [OFF_W-1:0] OFF_STATUS = 6'h24;

  localparam logic [ADDR_W-1:0] GLB_STATUS = 10'h000;
  localparam logic [ADDR_W-1:0] GLB_PERIOD = 10'h004;
  localparam logic [ADDR_W-1:0] CH_BASE0   = 10'h1C0;
  localparam logic [ADDR_W-1:0] CH_STRIDE  = 10'h040;

  localparam int B_ENABLE   = 31;
  localparam int B_RUNUP_EN = 30;
  localparam int B_RUNDN_EN = 29;
  localparam int B_RUNUP_F  = 26;
  localparam int B_RUNDN_F  = 23;
  localparam int B_AVGUP_EN = 21;
  localparam int B_AVGDN_EN = 20;
  localparam int B_PERIODIC = 18;
  localparam int B_WIN_F    = 10;
  localparam int FLD_W      = 3;

  // status bits 31..28 held as a 4-bit vector in this order
  typedef struct packed {
    logic run_up;
    logic run_dn;
    logic avg_up;
    logic avg_dn;
  } flags_t;

  function automatic logic [ADDR_W-1:0] chan_base(input int ch);
    return CH_BASE0 + ADDR_W'(ch) * CH_STRIDE;
  endfunction

  function automatic int chan_irq_bit(input int ch);
    return 26 - ch;
  endfunction
endpackage

// File: rtl/actmon_period_timer.sv
module actmon_period_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [PW-1:0] wdata_i,
  input  logic          tick_i,
  output logic [PW-1:0] period_o,
  output logic [PW-1:0] cnt_o,
  output logic          end_o
);
  logic [PW-1:0] period_q, cnt_q;

  assign end_o    = tick_i && (cnt_q == period_q);
  assign period_o = period_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (wr_i) begin
      period_q <= wdata_i;
      cnt_q    <= '0;
    end else if (tick_i) begin
      cnt_q <= end_o ? '0 : cnt_q + PW'(1);
    end
  end
endmodule

// File: rtl/actmon_avg_update.sv
module actmon_avg_update #(
  parameter int DW    = 32,
  parameter int WIN_W = 3
) (
  input  logic [DW-1:0]    avg_i,
  input  logic [DW-1:0]    sample_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [DW-1:0]    avg_o
);
  logic signed [DW+1:0] diff, delta, sum;
  logic [WIN_W:0]       shamt;

  always_comb begin
    shamt = (WIN_W+1)'(win_i) + (WIN_W+1)'(1);
    diff  = $signed({2'b00, sample_i}) - $signed({2'b00, avg_i});
    delta = diff >>> shamt;
    sum   = $signed({2'b00, avg_i}) + delta;
    avg_o = DW'(sum);
  end
endmodule

// File: rtl/actmon_breach_run.sv
module actmon_breach_run #(
  parameter int RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             hit_i,
  input  logic [RUN_W-1:0] need_m1_i,
  output logic             fire_o
);
  logic [RUN_W:0] cnt_q, nxt, need;

  assign nxt    = cnt_q + (RUN_W+1)'(1);
  assign need   = (RUN_W+1)'(need_m1_i) + (RUN_W+1)'(1);
  assign fire_o = step_i && hit_i && (nxt >= need);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (step_i) begin
      if (!hit_i || fire_o) cnt_q <= '0;
      else                  cnt_q <= nxt;
    end
  end
endmodule

// File: rtl/actmon_channel.sv
module actmon_channel
  import actmon_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [DW-1:0]    wdata,
  input  logic             evt,
  input  logic             period_end,
  output logic [DW-1:0]    rdata,
  output logic             irq_o,
  output logic [3:0]       status_o,
  output logic [DW-1:0]    avg_o,
  output logic [DW-1:0]    acc_o,
  output logic             active_o
);
  logic [DW-1:0] ctrl_q, upper_q, lower_q, avg_hi_q, avg_lo_q, weight_q, avg_q, acc_q;
  flags_t        status_q, set_v, clr_v, en_v;
  logic [DW:0]   acc_plus;
  logic [DW-1:0] acc_sat, sample, avg_next;
  logic          active, step, above, below, fire_up, fire_dn;

  assign active   = ctrl_q[B_ENABLE] && ctrl_q[B_PERIODIC];
  assign step     = period_end && active;
  assign acc_plus = {1'b0, acc_q} + {1'b0, weight_q};
  assign acc_sat  = acc_plus[DW] ? '1 : acc_plus[DW-1:0];
  assign sample   = evt ? acc_sat : acc_q;
  assign above    = sample > upper_q;
  assign below    = sample < lower_q;

  actmon_avg_update #(.DW(DW), .WIN_W(FLD_W)) u_avg (
    .avg_i(avg_q), .sample_i(sample),
    .win_i(ctrl_q[B_WIN_F +: FLD_W]), .avg_o(avg_next)
  );

  actmon_breach_run #(.RUN_W(FLD_W)) u_run_up (
    .clk(clk), .rst_n(rst_n), .clr_i(!active), .step_i(step), .hit_i(above),
    .need_m1_i(ctrl_q[B_RUNUP_F +: FLD_W]), .fire_o(fire_up)
  );

  actmon_breach_run #(.RUN_W(FLD_W)) u_run_dn (
    .clk(clk), .rst_n(rst_n), .clr_i(!active), .step_i(step), .hit_i(below),
    .need_m1_i(ctrl_q[B_RUNDN_F +: FLD_W]), .fire_o(fire_dn)
  );

  always_comb begin
    en_v.run_up = ctrl_q[B_RUNUP_EN];
    en_v.run_dn = ctrl_q[B_RUNDN_EN];
    en_v.avg_up = ctrl_q[B_AVGUP_EN];
    en_v.avg_dn = ctrl_q[B_AVGDN_EN];
    set_v.run_up = fire_up && en_v.run_up;
    set_v.run_dn = fire_dn && en_v.run_dn;
    set_v.avg_up = step && (avg_next > avg_hi_q) && en_v.avg_up;
    set_v.avg_dn = step && (avg_next < avg_lo_q) && en_v.avg_dn;
    clr_v = (wr_en && off == OFF_STATUS) ? flags_t'(wdata[DW-1 -: 4]) : flags_t'(4'b0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      upper_q  <= '0;
      lower_q  <= '0;
      avg_hi_q <= '0;
      avg_lo_q <= '0;
      weight_q <= '0;
    end else if (wr_en) begin
      case (off)
        OFF_CTRL:   ctrl_q   <= wdata;
        OFF_UPPER:  upper_q  <= wdata;
        OFF_LOWER:  lower_q  <= wdata;
        OFF_AVG_HI: avg_hi_q <= wdata;
        OFF_AVG_LO: avg_lo_q <= wdata;
        OFF_WEIGHT: weight_q <= wdata;
        default: ;
      endcase
    end
  end

  // seed write wins over a coincident period end
  always_ff @(posedge clk) begin
    if (!rst_n)                          avg_q <= '0;
    else if (wr_en && off == OFF_SEED)   avg_q <= wdata;
    else if (step)                       avg_q <= avg_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) acc_q <= '0;
    else if (period_end)   acc_q <= '0;
    else if (evt)          acc_q <= acc_sat;
  end

  // set takes priority over a coincident clear
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_v) | set_v;
  end

  always_comb begin
    case (off)
      OFF_CTRL:   rdata = ctrl_q;
      OFF_UPPER:  rdata = upper_q;
      OFF_LOWER:  rdata = lower_q;
      OFF_SEED:   rdata = avg_q;
      OFF_AVG_HI: rdata = avg_hi_q;
      OFF_AVG_LO: rdata = avg_lo_q;
      OFF_WEIGHT: rdata = weight_q;
      OFF_AVG:    rdata = avg_q;
      OFF_STATUS: rdata = {status_q, {(DW-4){1'b0}}};
      default:    rdata = '0;
    endcase
  end

  assign irq_o    = ctrl_q[B_ENABLE] && |(status_q & en_v);
  assign status_o = status_q;
  assign avg_o    = avg_q;
  assign acc_o    = acc_q;
  assign active_o = active;
endmodule

// File: rtl/actmon_top.sv
module actmon_top
  import actmon_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = DATA_W,
  parameter int AW     = ADDR_W,
  parameter int PW     = PERIOD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NUM_CH-1:0] act_evt,
  input  logic              ms_tick,
  output logic              irq
);
  logic                          period_end;
  logic [PW-1:0]                 period_q, tick_cnt;
  logic [NUM_CH-1:0]             ch_sel, ch_irq, ch_active;
  logic [NUM_CH-1:0][DW-1:0]     ch_rdata, ch_avg, ch_acc;
  logic [NUM_CH-1:0][3:0]        ch_status;

  actmon_period_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr_en && reg_addr == GLB_PERIOD),
    .wdata_i(reg_wdata[PW-1:0]), .tick_i(ms_tick),
    .period_o(period_q), .cnt_o(tick_cnt), .end_o(period_end)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = chan_base(c);
    assign ch_sel[c] = reg_addr[AW-1:OFF_W] == BASE[AW-1:OFF_W];

    actmon_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en && ch_sel[c]), .off(reg_addr[OFF_W-1:0]),
      .wdata(reg_wdata), .evt(act_evt[c]), .period_end(period_end),
      .rdata(ch_rdata[c]), .irq_o(ch_irq[c]), .status_o(ch_status[c]),
      .avg_o(ch_avg[c]), .acc_o(ch_acc[c]), .active_o(ch_active[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == GLB_STATUS) begin
      for (int c = 0; c < NUM_CH; c++) reg_rdata[chan_irq_bit(c)] = ch_irq[c];
    end else if (reg_addr == GLB_PERIOD) begin
      reg_rdata = DW'(period_q);
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (ch_sel[c]) reg_rdata = ch_rdata[c];
    end
  end

  assign irq = |ch_irq;
endmodule

// File: rtl/actmon_checker.sv
module actmon_checker #(
  parameter int NUM_CH = 2,
  parameter int DW     = 32,
  parameter int PW     = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      irq,
  input logic                      reg_wr_en,
  input logic                      period_end,
  input logic [PW-1:0]             tick_cnt,
  input logic [PW-1:0]             period_q,
  input logic [NUM_CH-1:0][3:0]    ch_status,
  input logic [NUM_CH-1:0][DW-1:0] ch_avg,
  input logic [NUM_CH-1:0][DW-1:0] ch_acc,
  input logic [NUM_CH-1:0]         ch_active
);
  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= period_q); // R3

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ch_status)); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_STATUS_RISES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ch_status[c] & ~$past(ch_status[c]))) |-> $past(period_end)); // R8

    AST_AVG_MOVES_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_avg[c]) |-> ($past(period_end) || $past(reg_wr_en))); // R4

    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_active[c] |=> ch_acc[c] == '0); // R10
  end
endmodule

bind actmon_top actmon_checker #(.NUM_CH(NUM_CH), .DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .reg_wr_en(reg_wr_en),
  .period_end(period_end), .tick_cnt(tick_cnt), .period_q(period_q),
  .ch_status(ch_status), .ch_avg(ch_avg), .ch_acc(ch_acc), .ch_active(ch_active)
);

// File: tb/actmon_top_test.sv
module actmon_top_test;
  localparam logic [9:0] GS = 10'h000, GP = 10'h004, C0 = 10'h1C0, C1 = 10'h200;
  localparam logic [31:0] EN = 32'h8000_0000, RUP = 32'h4000_0000, RDN = 32'h2000_0000;
  localparam logic [31:0] AUP = 32'h0020_0000, ADN = 32'h0010_0000, PER = 32'h0004_0000;

  typedef struct packed {
    logic [31:0] seed;
    logic [31:0] weight;
    logic [31:0] nev;
    logic [31:0] k;
    logic [31:0] expv;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'd0,    32'd16,   32'd8,   32'd0, 32'd64},
    '{32'd1000, 32'd10,   32'd5,   32'd1, 32'd762},
    '{32'd100,  32'd4,    32'd25,  32'd2, 32'd100},
    '{32'd0,    32'd1024, 32'd3,   32'd6, 32'd24},
    '{32'd7,    32'd1,    32'd0,   32'd0, 32'd3},
    '{32'd500,  32'd3,    32'd100, 32'd0, 32'd400}
  };

  logic        clk = 0, rst_n = 0, reg_wr_en = 0, ms_tick = 0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  act_evt = '0;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  actmon_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_evt(act_evt),
    .ms_tick(ms_tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic rd_irq(output logic [31:0] v);
    @(negedge clk); #1 v = {31'b0, irq};
  endtask

  task automatic tick();
    @(negedge clk); ms_tick = 1;
    @(negedge clk); ms_tick = 0;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); act_evt[ch] = 1;
    @(negedge clk); act_evt[ch] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(C0, d);          chk("R1 ctrl0", d, 0);
    rd(GP, d);          chk("R1 period", d, 0);
    rd(C1 + 10'h20, d); chk("R1 avg1", d, 0);
    rd(GS, d);          chk("R1 gstatus", d, 0);
    rd_irq(d);          chk("R1 irq", d, 0);

    // R2 / R4 vector table
    for (int i = 0; i < 6; i++) begin
      wr(C0, 0);
      wr(GP, 3);
      wr(C0 + 10'h18, VEC[i].weight);
      wr(C0 + 10'h0C, VEC[i].seed);
      wr(C0, EN | PER | (VEC[i].k << 10));
      for (int e = 0; e < int'(VEC[i].nev); e++) pulse(0);
      repeat (4) tick();
      rd(C0 + 10'h20, d);
      chk($sformatf("R2/R4 vector %0d", i), d, VEC[i].expv);
    end

    // R3 period length
    wr(C0, 0); wr(GP, 2); wr(C0 + 10'h18, 100); wr(C0 + 10'h0C, 0); wr(C0, EN | PER);
    rd(GP, d); chk("R3 period readback", d, 2);
    pulse(0); tick(); tick();
    rd(C0 + 10'h20, d); chk("R3 before end", d, 0);
    tick();
    rd(C0 + 10'h20, d); chk("R3 at end", d, 50);

    // R5 consecutive above, N=3
    wr(C0, 0); wr(GP, 0); wr(C0 + 10'h04, 10);
    wr(C0, EN | PER | RUP | (32'd2 << 26));
    repeat (2) begin pulse(0); tick(); end
    rd(C0 + 10'h24, d); chk("R5 two periods", d, 0);
    rd_irq(d); chk("R5 irq low", d, 0);
    pulse(0); tick();
    rd(C0 + 10'h24, d); chk("R5 third period", d, 32'h8000_0000);
    rd_irq(d); chk("R9 irq high", d, 1);
    rd(GS, d); chk("R9 gstatus ch0", d, 32'h0400_0000);
    wr(C0 + 10'h24, 32'hFFFF_FFFF);
    rd(C0 + 10'h24, d); chk("R8 clear", d, 0);
    rd_irq(d); chk("R8 irq after clear", d, 0);
    pulse(0); tick(); pulse(0); tick(); tick(); pulse(0); tick(); pulse(0); tick();
    rd(C0 + 10'h24, d); chk("R5 run broken", d, 0);

    // R6 consecutive below on channel 1, N=2
    wr(C1, 0); wr(C1 + 10'h08, 50);
    wr(C1, EN | PER | RDN | (32'd1 << 23));
    tick();
    rd(C1 + 10'h24, d); chk("R6 one period", d, 0);
    tick();
    rd(C1 + 10'h24, d); chk("R6 two periods", d, 32'h4000_0000);
    rd(GS, d); chk("R9 gstatus ch1", d, 32'h0200_0000);
    wr(C1, 0);
    rd_irq(d); chk("R10 stop masks irq", d, 0);
    rd(C1 + 10'h24, d); chk("R8 sticky after stop", d, 32'h4000_0000);
    wr(C1 + 10'h24, 32'hFFFF_FFFF);

    // R7 average watermarks
    wr(C0, 0); wr(C0 + 10'h18, 300); wr(C0 + 10'h0C, 0); wr(C0 + 10'h10, 100);
    wr(C0, EN | PER | AUP);
    pulse(0); tick();
    rd(C0 + 10'h24, d); chk("R7 avg above", d, 32'h2000_0000);
    rd_irq(d); chk("R9 avg irq", d, 1);
    wr(C0 + 10'h14, 1000); wr(C0, EN | PER | AUP | ADN); wr(C0 + 10'h24, 32'hFFFF_FFFF);
    tick();
    rd(C0 + 10'h20, d); chk("R4 decay", d, 75);
    rd(C0 + 10'h24, d); chk("R7 avg below", d, 32'h1000_0000);

    // R8 clear colliding with a set
    wr(C0 + 10'h14, 0); wr(C0 + 10'h24, 32'hFFFF_FFFF);
    pulse(0);
    @(negedge clk); ms_tick = 1; reg_wr_en = 1; reg_addr = C0 + 10'h24; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); ms_tick = 0; reg_wr_en = 0;
    rd(C0 + 10'h24, d); chk("R8 set beats clear", d, 32'h2000_0000);
    rd(C0 + 10'h20, d); chk("R4 collision avg", d, 187);
    wr(C0 + 10'h24, 32'hFFFF_FFFF);

    // R10 inactive channel ignores stimulus
    wr(C0, EN | AUP);
    pulse(0); pulse(0); tick();
    rd(C0 + 10'h20, d); chk("R10 no periodic avg", d, 187);
    rd(C0 + 10'h24, d); chk("R10 no periodic status", d, 0);
    wr(C0, 0);
    pulse(0); tick();
    rd(C0 + 10'h20, d); chk("R10 stopped avg", d, 187);
    rd_irq(d); chk("R10 stopped irq", d, 0);

    // R11 address map
    rd(10'h100, d); chk("R11 unmapped", d, 0);
    wr(C1 + 10'h18, 32'h1234);
    rd(C1 + 10'h18, d); chk("R11 ch1 weight", d, 32'h1234);
    rd(C0 + 10'h18, d); chk("R11 ch0 weight", d, 300);
    rd(C1 + 10'h3C, d); chk("R11 unmapped offset", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule